// File: doc/BRIEF.md
# Cache Line Coherence State Controller

This block keeps the four-state coherence status (Invalid, Shared, Exclusive, Modified) of a single cache line and advances it on accesses issued by the local processor while the cache runs in write-back mode. Each cycle it may see a read or write request together with a hit indication. A read miss starts a line fill, and the fill ends with a completion strobe. During the fill the block watches the burst-ready strobe and captures the bus write-back/write-through signal on the first beat.

When the fill completes, the captured bus signal and the page write-through attribute of the missing access decide whether the line becomes Exclusive or Shared. Writes that memory must see raise a combinational bus-write request in the same cycle. Evicting a Modified line raises a copy-back request, and the line stays Modified until the new fill overwrites it. A global cache-disable bit stops fills from changing the state. Snooping, tags and data storage are handled by neighbouring blocks.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Reset, asserted low, places the line in Invalid. The state is encoded on state_o as Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: The page write-through attribute is taken from the read-miss cycle that starts a fill. When the fill completes with a captured bus signal of 1 and an attribute of 0, the state becomes Exclusive on the next clock edge.
- R3: When a fill completes with a captured bus signal of 0, or with a page write-through attribute of 1, the state becomes Shared.
- R4: The bus write-back/write-through signal is captured on the first burst-ready beat of a fill. Its value on later beats has no effect on the resulting state. If completion arrives with no earlier beat, the value present in the completion cycle is used.
- R5: A write hit to an Exclusive line moves it to Modified, and bus_wr_o stays 0.
- R6: A write hit to a Modified line keeps it Modified, and bus_wr_o stays 0.
- R7: A write hit to a Shared line keeps it Shared and raises bus_wr_o in the same cycle.
- R8: A write to an Invalid line, or a write with hit low, raises bus_wr_o in the same cycle and leaves the state unchanged.
- R9: A read hit never changes the state.
- R10: A read miss on a Modified line raises copy_back_o in the same cycle. The line then stays Modified until the fill completes.
- R11: While cache_dis_i is 1, a read miss starts no fill and raises no copy-back. A completion strobe seen with cache_dis_i at 1 ends the fill and leaves the state unchanged.
- R12: While a fill is in progress, read and write requests are ignored: they raise neither bus_wr_o nor copy_back_o, and they do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Processor read request (has priority over a write) |
| wr_req_i | input | 1 | Processor write request |
| hit_i | input | 1 | Tag match for the current request |
| brdy_i | input | 1 | Burst-ready beat of the line fill |
| fill_done_i | input | 1 | Line fill completed |
| pwt_i | input | 1 | Page write-through attribute of the current access |
| wbwt_i | input | 1 | Bus write-back (1) or write-through (0) indication |
| cache_dis_i | input | 1 | Global cache disable |
| state_o | output | 2 | Current line state |
| bus_wr_o | output | 1 | External bus write required for this access |
| copy_back_o | output | 1 | Modified line must be copied back on replacement |

## Verification
Assertions check the following on every cycle: the Exclusive-to-Modified promotion, silent writes to owned lines, the forced bus write on Shared writes, the stability of the state under read hits, during a fill and under cache-disable completions, and the silence of both request outputs while a fill is in progress. Some effects only the bench scenarios can show. These are the choice between Exclusive and Shared at the end of a fill, the fact that later burst beats cannot change the captured bus signal, the reset encoding, and writes to an Invalid line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  localparam int unsigned ST_W = 2;
  typedef enum logic [ST_W-1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;
endpackage

// File: rtl/mesi_fill_track.sv
module mesi_fill_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pwt_i,
  input  logic brdy_i,
  input  logic wbwt_i,
  input  logic done_i,
  output logic active_o,
  output logic wb_o,
  output logic pwt_o
);
  logic active_q, first_q, wb_q, pwt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      wb_q     <= 1'b0;
      pwt_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      first_q  <= 1'b1;
      pwt_q    <= pwt_i;
    end else if (active_q) begin
      if (brdy_i && first_q) begin
        wb_q    <= wbwt_i;
        first_q <= 1'b0;
      end
      if (done_i) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  // completion on the first beat uses the live value
  assign wb_o     = first_q ? wbwt_i : wb_q;
  assign pwt_o    = pwt_q;

  assert_wb_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !first_q && !done_i) |=> $stable(wb_o));
endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_pkg::*;
(
  input  line_st_e st_i,
  input  logic     busy_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     hit_i,
  input  logic     cd_i,
  input  logic     done_i,
  input  logic     wb_i,
  input  logic     pwt_i,
  output line_st_e st_d_o,
  output logic     bus_wr_o,
  output logic     copy_back_o,
  output logic     fill_start_o
);
  logic valid_hit, rd_acc, wr_acc, rd_miss, wr_hit, owned;

  always_comb begin
    valid_hit = hit_i && (st_i != ST_I);
    rd_acc    = rd_i && !busy_i;
    wr_acc    = wr_i && !rd_i && !busy_i;
    rd_miss   = rd_acc && !valid_hit;
    wr_hit    = wr_acc && valid_hit;
    owned     = (st_i == ST_E) || (st_i == ST_M);

    fill_start_o = rd_miss && !cd_i;
    copy_back_o  = rd_miss && !cd_i && (st_i == ST_M);
    bus_wr_o     = wr_acc && !(wr_hit && owned);

    st_d_o = st_i;
    if (busy_i) begin
      if (done_i && !cd_i) st_d_o = (wb_i && !pwt_i) ? ST_E : ST_S;
    end else if (wr_hit && st_i == ST_E) begin
      st_d_o = ST_M;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_req_i,
  input  logic            wr_req_i,
  input  logic            hit_i,
  input  logic            brdy_i,
  input  logic            fill_done_i,
  input  logic            pwt_i,
  input  logic            wbwt_i,
  input  logic            cache_dis_i,
  output logic [ST_W-1:0] state_o,
  output logic            bus_wr_o,
  output logic            copy_back_o
);
  line_st_e st_q, st_d;
  logic busy, wb_eff, pwt_eff, fill_start;

  mesi_fill_track i_fill (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fill_start),
    .pwt_i    (pwt_i),
    .brdy_i   (brdy_i),
    .wbwt_i   (wbwt_i),
    .done_i   (fill_done_i),
    .active_o (busy),
    .wb_o     (wb_eff),
    .pwt_o    (pwt_eff)
  );

  mesi_next_state i_next (
    .st_i         (st_q),
    .busy_i       (busy),
    .rd_i         (rd_req_i),
    .wr_i         (wr_req_i),
    .hit_i        (hit_i),
    .cd_i         (cache_dis_i),
    .done_i       (fill_done_i),
    .wb_i         (wb_eff),
    .pwt_i        (pwt_eff),
    .st_d_o       (st_d),
    .bus_wr_o     (bus_wr_o),
    .copy_back_o  (copy_back_o),
    .fill_start_o (fill_start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_I;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  assert_wr_e_to_m_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && wr_req_i && !rd_req_i && hit_i && st_q == ST_E) |=> (st_q == ST_M));
  assert_owned_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && wr_req_i && !rd_req_i && hit_i && (st_q == ST_M || st_q == ST_E)) |-> !bus_wr_o);
  assert_shared_wr_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && wr_req_i && !rd_req_i && hit_i && st_q == ST_S) |-> (bus_wr_o ##1 st_q == ST_S));
  assert_rd_hit_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && rd_req_i && hit_i && st_q != ST_I) |=> $stable(st_q));
  assert_hold_in_fill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fill_done_i) |=> $stable(st_q));
  assert_cd_no_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_dis_i && (fill_done_i || rd_req_i)) |=> $stable(st_q));
  assert_quiet_in_fill_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (!bus_wr_o && !copy_back_o));
endmodule

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
  localparam time TCK = 8ns;
  localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd = 0, wr = 0, hit = 0, brdy = 0, done = 0, pwt = 0, wbwt = 0, cd = 0;
  logic [1:0] state;
  logic bus_wr, cback;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(TCK/2) clk = ~clk;

  mesi_line_ctrl i_mesi_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd), .wr_req_i(wr), .hit_i(hit),
    .brdy_i(brdy), .fill_done_i(done), .pwt_i(pwt), .wbwt_i(wbwt),
    .cache_dis_i(cd), .state_o(state), .bus_wr_o(bus_wr), .copy_back_o(cback)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got st=%b bw=%b cb=%b, expected st=%b bw=%b cb=%b",
               tag, act[3:2], act[1], act[0], exp[3:2], exp[1], exp[0]);
    end
  endtask

  // driver: one cycle of stimulus plus the expected result
  task automatic step(input logic r, w, h, b, d, p, wb, c,
                      input logic [1:0] est, input logic ebw, ecb, input string tag);
    @(negedge clk);
    rd = r; wr = w; hit = h; brdy = b; done = d; pwt = p; wbwt = wb; cd = c;
    exp_q.push_back({est, ebw, ecb});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    step(0,0,0,0,0,0,0,0, state, 0, 0, "idle");
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    {rd, wr, hit, brdy, done, pwt, wbwt, cd} = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(tag, {state, bus_wr, cback}, {I, 1'b0, 1'b0});
    rst_n = 1'b1;
  endtask

  // monitor: outputs of this cycle before the edge, state after it
  initial begin
    logic bw_s, cb_s;
    forever begin
      @(negedge clk);
      #3;
      bw_s = bus_wr; cb_s = cback;
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {state, bw_s, cb_s}, e);
      end
    end
  end

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    //            rd wr h  b  d  p  wb cd
    do_reset("R1 reset state");
    // miss fill, wb sampled 1 on first beat, later beat 0 ignored
    step(1,0,0,0,0,0,0,0, I,0,0, "R2 miss start");
    step(0,0,0,1,0,0,1,0, I,0,0, "R4 first beat");
    step(0,0,0,1,0,0,0,0, I,0,0, "R4 later beat");
    step(0,0,0,1,1,0,0,0, E,0,0, "R2 R4 fill to E");
    step(1,0,1,0,0,0,0,0, E,0,0, "R9 read hit E");
    step(0,1,1,0,0,0,0,0, M,0,0, "R5 write hit E");
    step(0,1,1,0,0,0,0,0, M,0,0, "R6 write hit M");
    step(1,0,1,0,0,0,0,0, M,0,0, "R9 read hit M");
    // evict modified line, page write-through set
    step(1,0,0,0,0,1,0,0, M,0,1, "R10 copy-back");
    step(0,0,0,1,0,0,1,0, M,0,0, "R10 hold M");
    step(0,1,1,0,0,0,1,0, M,0,0, "R12 write in fill");
    step(1,0,0,0,0,0,1,0, M,0,0, "R12 read in fill");
    step(0,0,0,1,1,0,1,0, S,0,0, "R3 pwt forces S");
    step(0,1,1,0,0,0,0,0, S,1,0, "R7 write hit S");
    step(1,0,1,0,0,0,0,0, S,0,0, "R9 read hit S");
    idle();
    do_reset("R1 reset again");
    step(0,1,0,0,0,0,0,0, I,1,0, "R8 write miss");
    step(0,1,1,0,0,0,0,0, I,1,0, "R8 write on invalid");
    step(1,0,0,0,0,0,0,0, I,0,0, "R3 miss start");
    step(0,0,0,1,0,0,0,0, I,0,0, "R4 first beat 0");
    step(0,0,0,1,0,0,1,0, I,0,0, "R4 later beat 1");
    step(0,0,0,1,1,0,1,0, S,0,0, "R3 R4 fill to S");
    do_reset("R1 reset third");
    // completion without earlier beat uses live value
    step(1,0,0,0,0,0,0,0, I,0,0, "R2 miss start");
    step(0,0,0,1,1,0,1,0, E,0,0, "R4 single beat E");
    step(0,1,1,0,0,0,0,0, M,0,0, "R5 to M");
    step(1,0,0,0,0,0,0,1, M,0,0, "R11 miss with cd");
    step(0,0,0,1,1,0,0,1, M,0,0, "R11 stray done");
    step(1,0,0,0,0,0,0,0, M,0,1, "R10 evict M");
    step(0,0,0,1,0,0,0,0, M,0,0, "R10 hold M");
    step(0,0,0,1,1,0,0,1, M,0,0, "R11 done with cd");
    step(0,0,0,0,1,0,0,0, M,0,0, "R11 fill ended");
    step(0,1,1,0,0,0,0,0, M,0,0, "R6 write M after");
    idle();
    idle();
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule